// File: doc/BRIEF.md
# Microframe Index Timer with Rollover Event

This block keeps the microframe index for a USB host controller's runtime register space. A prescaler divides the system clock down to one tick per 125 µs microframe. Each tick advances an index that is `IDX_W` bits wide, 14 by default. Software reads the index through a small register read port at runtime offset 0x00. A command-register write port lets software start and stop the controller and reset it. It also arms a notification for each time the index rolls over.

Two events put the time base back to zero: a write that takes the controller from stopped to running, and a controller-reset write. In both cases the prescaler restarts as well, so the first increment comes one full microframe later. When the index rolls over from all ones to zero while both the run bit and the rollover-enable bit are set, the block raises an event request toward the event logic. The request carries a fixed event type and a success completion code, and it holds until the event logic accepts it. If a second rollover arrives before the first has been accepted, the block sets a sticky overflow flag. Only a reset clears that flag.

Top module: `ufidx_timer`

## Requirements
- R1: After `rst_n` is released, the index reads 0, `evt_valid` is 0 and `evt_overflow` is 0.
- R2: The index increases by exactly one every `CYCLES_PER_UFRAME` clock cycles. The first increment after a restart lands `CYCLES_PER_UFRAME` cycles after the restarting clock edge.
- R3: A read at `rd_addr` 0 returns the index zero-extended to 32 bits. A read at any other offset returns 0. The read path is combinational.
- R4: The index steps from 2^`IDX_W`−1 to 0 and keeps counting, so with the defaults 0x3FFF is followed by 0.
- R5: A command write with bit 0 (run) equal to 1 while run is currently 0 restarts both the index and the prescaler from zero. A write with run equal to 1 while already running does not restart them.
- R6: A command write with bit 1 (controller reset) equal to 1 restarts the time base, clears run and rollover-enable, drops any pending event and clears the overflow flag. Bit 1 is never retained.
- R7: A rollover raises `evt_valid` on the clock edge where the index returns to 0, but only if run (bit 0) and rollover-enable (bit 10) are both 1 before that edge. Otherwise the rollover is silent.
- R8: While `evt_valid` is 1, `evt_type` is 39 and `evt_code` is 1, and both are 0 otherwise. `evt_valid` stays high until a cycle with `evt_ready` high, and falls on the next edge unless a new rollover event arrives on that same edge.
- R9: A raised rollover that finds an event still pending and not accepted in that cycle sets `evt_overflow`. The flag stays set until `rst_n` or a controller-reset write.
- R10: Command bits outside mask 0xC0F have no effect. Clearing run stops neither the index nor the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 32 | Command register write value |
| rd_addr | input | RD_AW | Runtime register read offset |
| rd_data | output | 32 | Read data (index at offset 0) |
| evt_valid | output | 1 | Rollover event request pending |
| evt_ready | input | 1 | Event logic accepts the request |
| evt_type | output | 6 | Event type (39 while valid) |
| evt_code | output | 8 | Completion code (1 while valid) |
| evt_overflow | output | 1 | Sticky: rollover lost behind a pending event |

## Verification
A command write acts on the next clock edge, so a restart or a controller reset is visible on `rd_data` from the following cycle. A rollover event appears on the same edge on which the index returns to zero, and an accepted event falls one edge after the handshake. The read path is combinational and has no latency. The bench keeps a cycle-accurate model that is advanced on each rising edge from the inputs driven before it. It compares the ports at the falling edge, when every register on the way has settled. It sets `rd_addr` and waits one time step before it compares read data.

// File: rtl/ufidx_pkg.sv
package ufidx_pkg;
   typedef enum logic [5:0] {
      EVT_NONE       = 6'd0,
      EVT_UFIDX_WRAP = 6'd39
   } evt_type_e;

   typedef enum logic [7:0] {
      CC_NONE    = 8'd0,
      CC_SUCCESS = 8'd1
   } evt_code_e;

   localparam logic [31:0] CMD_WR_MASK = 32'h0000_0C0F;
   localparam int          CMD_RUN_BIT = 0;
   localparam int          CMD_RST_BIT = 1;
   localparam int          CMD_EWE_BIT = 10;
endpackage

// File: rtl/ufidx_cmd.sv
module ufidx_cmd
   import ufidx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic        arm_o,
   output logic        restart_o,
   output logic        flush_o
);
   logic run_q, ewe_q;
   logic w_run, w_rst, w_ewe;
   logic unused_wr;

   assign w_run = wr_data[CMD_RUN_BIT] & CMD_WR_MASK[CMD_RUN_BIT];
   assign w_rst = wr_data[CMD_RST_BIT] & CMD_WR_MASK[CMD_RST_BIT];
   assign w_ewe = wr_data[CMD_EWE_BIT] & CMD_WR_MASK[CMD_EWE_BIT];
   assign unused_wr = ^wr_data;

   assign flush_o   = wr_en & w_rst;
   assign restart_o = flush_o | (wr_en & w_run & ~run_q);
   assign arm_o     = run_q & ewe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ewe_q <= 1'b0;
      end else if (flush_o) begin
         run_q <= 1'b0;
         ewe_q <= 1'b0;
      end else if (wr_en) begin
         run_q <= w_run;
         ewe_q <= w_ewe;
      end
   end

   // R6
   hc_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CMD_RST_BIT]) |=> (!arm_o && !run_q));
endmodule

// File: rtl/ufidx_prescale.sv
module ufidx_prescale #(
   parameter int CYCLES = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("ufidx_prescale: CYCLES must be at least 1");
      end

      if (CYCLES == 1) begin : g_passthru
         logic unused_in;
         assign unused_in = restart ^ clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int PW = $clog2(CYCLES);
         localparam logic [PW-1:0] LAST = PW'(CYCLES - 1);
         logic [PW-1:0] pre_q;

         assign tick = (pre_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (restart || tick)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end

         // R5
         pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (pre_q == '0 && !tick));
      end
   endgenerate
endmodule

// File: rtl/ufidx_count.sv
module ufidx_count #(
   parameter int IDX_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   output logic [IDX_W-1:0] idx_o,
   output logic             wrap_o
);
   logic [IDX_W-1:0] idx_q;

   assign idx_o  = idx_q;
   assign wrap_o = tick & (&idx_q) & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (restart)
         idx_q <= '0;
      else if (tick)
         idx_q <= idx_q + 1'b1;
   end

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart) |=> (idx_q == $past(idx_q) + 1'b1));

   // R5
   idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idx_q == '0));

   // R4
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (idx_q == '0));
endmodule

// File: rtl/ufidx_evt.sv
module ufidx_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic arm,
   input  logic flush,
   input  logic ready,
   output logic valid_o,
   output logic ovf_o
);
   logic valid_q, ovf_q, fire;

   assign fire    = wrap & arm;
   assign valid_o = valid_q;
   assign ovf_o   = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else if (flush) begin
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (fire)
            valid_q <= 1'b1;
         else if (valid_q && ready)
            valid_q <= 1'b0;
         if (fire && valid_q && !ready)
            ovf_q <= 1'b1;
      end
   end

   // R8
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready && !flush) |=> valid_q);

   // R7
   no_spurious_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && !(wrap && arm)) |=> !valid_q);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !flush) |=> ovf_q);
endmodule

// File: rtl/ufidx_timer.sv
module ufidx_timer
   import ufidx_pkg::*;
#(
   parameter int CYCLES_PER_UFRAME = 12500,
   parameter int IDX_W             = 14,
   parameter int RD_AW             = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr_en,
   input  logic [31:0]      cmd_wr_data,
   input  logic [RD_AW-1:0] rd_addr,
   output logic [31:0]      rd_data,
   output logic             evt_valid,
   input  logic             evt_ready,
   output logic [5:0]       evt_type,
   output logic [7:0]       evt_code,
   output logic             evt_overflow
);
   generate
      if (IDX_W < 1 || IDX_W > 32) begin : g_bad_idx
         $error("ufidx_timer: IDX_W must be 1..32");
      end
      if (RD_AW < 1) begin : g_bad_aw
         $error("ufidx_timer: RD_AW must be at least 1");
      end
   endgenerate

   logic             arm, restart, flush, tick, wrap;
   logic [IDX_W-1:0] idx;

   ufidx_cmd i_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cmd_wr_en),
      .wr_data   (cmd_wr_data),
      .arm_o     (arm),
      .restart_o (restart),
      .flush_o   (flush)
   );

   ufidx_prescale #(.CYCLES(CYCLES_PER_UFRAME)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   ufidx_count #(.IDX_W(IDX_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (restart),
      .idx_o   (idx),
      .wrap_o  (wrap)
   );

   ufidx_evt i_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .arm     (arm),
      .flush   (flush),
      .ready   (evt_ready),
      .valid_o (evt_valid),
      .ovf_o   (evt_overflow)
   );

   assign rd_data  = (rd_addr == '0) ? 32'(idx) : 32'd0;
   assign evt_type = evt_valid ? EVT_UFIDX_WRAP : EVT_NONE;
   assign evt_code = evt_valid ? CC_SUCCESS : CC_NONE;

   // R3
   rd_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != '0) |-> (rd_data == 32'd0));
endmodule

// File: tb/test_ufidx_timer.sv
module test_ufidx_timer;
   localparam int CPU    = 3;
   localparam int W      = 5;
   localparam int AW     = 5;
   localparam int PERIOD = CPU * (1 << W);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr_en = 1'b0;
   logic [31:0]   cmd_wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic          evt_valid, evt_overflow;
   logic          evt_ready = 1'b1;
   logic [5:0]    evt_type;
   logic [7:0]    evt_code;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   int  m_n = 0;
   bit  m_run = 0, m_ewe = 0, m_valid = 0, m_ovf = 0;
   bit  m_wrap, m_pv;

   always #5 clk = ~clk;

   ufidx_timer #(.CYCLES_PER_UFRAME(CPU), .IDX_W(W), .RD_AW(AW)) i_ufidx_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wr_en    (cmd_wr_en),
      .cmd_wr_data  (cmd_wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .evt_valid    (evt_valid),
      .evt_ready    (evt_ready),
      .evt_type     (evt_type),
      .evt_code     (evt_code),
      .evt_overflow (evt_overflow)
   );

   // reference model built from the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_n = 0; m_run = 0; m_ewe = 0; m_valid = 0; m_ovf = 0;
      end else if (cmd_wr_en && cmd_wr_data[1]) begin
         m_n = 0; m_run = 0; m_ewe = 0; m_valid = 0; m_ovf = 0;
      end else begin
         m_pv   = m_valid;
         m_wrap = 1'b0;
         if (cmd_wr_en && cmd_wr_data[0] && !m_run)
            m_n = 0;
         else begin
            m_n    = (m_n + 1) % PERIOD;
            m_wrap = (m_n == 0);
         end
         if (m_pv && evt_ready) m_valid = 0;
         if (m_wrap && m_run && m_ewe) begin
            if (m_pv && !evt_ready) m_ovf = 1;
            m_valid = 1;
         end
         if (cmd_wr_en) begin
            m_run = cmd_wr_data[0];
            m_ewe = cmd_wr_data[10];
         end
      end
   end

   function automatic logic [31:0] exp_idx();
      return 32'(m_n / CPU);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic verify(input string r_idx, input string r_evt, input string r_ovf);
      rd_addr = '0;
      #1;
      chk(r_idx, rd_data, exp_idx());
      chk(r_evt, {31'd0, evt_valid}, {31'd0, m_valid});
      chk("R8", {18'd0, evt_type, evt_code}, m_valid ? {18'd0, 6'd39, 8'd1} : 32'd0);
      chk(r_ovf, {31'd0, evt_overflow}, {31'd0, m_ovf});
      rd_addr = AW'(1 + ($urandom % ((1 << AW) - 1)));
      #1;
      chk("R3", rd_data, 32'd0);
      rd_addr = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_cmd(input logic [31:0] v);
      cmd_wr_en   = 1'b1;
      cmd_wr_data = v;
      step();
      cmd_wr_en   = 1'b0;
      cmd_wr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      verify("R1", "R1", "R1");

      // R5: start running with rollover enabled
      wr_cmd(32'h0000_0401);
      verify("R5", "R7", "R9");
      for (int i = 0; i < CPU + 1; i++) begin
         step();
         verify("R2", "R7", "R9");
      end

      // R4 / R7: run up to the first rollover
      for (int i = 0; i < PERIOD + 2 && !m_valid; i++) begin
         step();
         verify("R4", "R7", "R9");
      end
      chk("R7", {31'd0, evt_valid}, 32'd1);
      chk("R4", rd_data, 32'd0);
      chk("R8", {26'd0, evt_type}, 32'd39);
      chk("R8", {24'd0, evt_code}, 32'd1);

      // R9: hold off ready across another rollover
      evt_ready = 1'b0;
      for (int i = 0; i < PERIOD; i++) begin
         step();
         verify("R4", "R8", "R9");
      end
      chk("R9", {31'd0, evt_overflow}, 32'd1);
      evt_ready = 1'b1;
      step();
      verify("R2", "R8", "R9");
      chk("R8", {31'd0, evt_valid}, 32'd0);

      // R10: unmasked garbage bits while running, then stop
      wr_cmd(32'hFFFF_F7F1);
      for (int i = 0; i < 10; i++) begin
         step();
         verify("R10", "R7", "R9");
      end
      wr_cmd(32'h0000_0000);
      for (int i = 0; i < 10; i++) begin
         step();
         verify("R10", "R7", "R9");
      end

      // R6: controller reset with overflow set
      chk("R9", {31'd0, evt_overflow}, 32'd1);
      wr_cmd(32'h0000_0002);
      verify("R6", "R6", "R6");
      chk("R6", {31'd0, evt_overflow}, 32'd0);

      // R7: run without rollover enable, no events across a rollover
      wr_cmd(32'h0000_0001);
      for (int i = 0; i < PERIOD + 5; i++) begin
         step();
         verify("R2", "R7", "R9");
      end
      chk("R7", {31'd0, evt_valid}, 32'd0);

      // R5: run write while running does not restart
      wr_cmd(32'h0000_0401);
      verify("R5", "R7", "R9");

      // constrained random phase
      for (int i = 0; i < 20000; i++) begin
         if ((i / 500) % 2 == 1) evt_ready = ($urandom % 8 == 0);
         else                    evt_ready = 1'b1;
         if ($urandom % 80 == 0) begin
            cmd_wr_en = 1'b1;
            case ($urandom % 6)
               0: cmd_wr_data = 32'h0000_0401;
               1: cmd_wr_data = 32'h0000_0001;
               2: cmd_wr_data = 32'h0000_0400;
               3: cmd_wr_data = 32'h0000_0000;
               4: cmd_wr_data = ($urandom % 4 == 0) ? 32'h0000_0002 : 32'h0000_0401;
               default: cmd_wr_data = 32'hFFFF_F3F0 | ($urandom & 32'h0000_0401);
            endcase
         end else begin
            cmd_wr_en   = 1'b0;
            cmd_wr_data = '0;
         end
         step();
         cmd_wr_en = 1'b0;
         verify("R2", "R8", "R9");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule